// File: doc/BRIEF.md
# Serial Converter Read Controller

This block is the host side of a serial link to an 8-bit analog-to-digital converter. When a request arrives it pulls the active-low chip select down and derives a serial clock from the system clock. The serial clock's half period is a parameter counted in system clocks. The block sends a five-bit command on its data output: a leading one, then a four-bit channel word. It throws away the single filler bit the converter returns next, and shifts in the eight result bits, most significant first.

In verified mode the controller keeps the clock running for seven more periods. During those periods it reads the converter's second copy of the result, which comes back least significant bit first starting at bit 1. It compares that copy with the first one. It can also check the converter's busy-status line during the result phase. When the transaction ends it releases chip select and presents the byte with a one-cycle valid pulse and two error flags. Afterwards it stays busy for one full serial period, so chip select is always high for at least that long between transactions.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, cs_n_o is 1, sclk_o, di_o, busy_o and valid_o are 0, and data_o and both error flags are 0.
- R2: A request is taken only in a cycle where busy_o is 0. busy_o is 1 from the next cycle. Requests made while busy_o is 1 have no effect.
- R3: sclk_o is 0 whenever cs_n_o is 1. During a transaction, every serial period has HALF_DIV system cycles low followed by HALF_DIV cycles high, and the first period starts low.
- R4: di_o carries 1 in period 0, then mux_cfg_i bits 3, 2, 1 and 0 in periods 1 to 4, and 0 after that. It changes only in the cycle where sclk_o falls, or on acceptance.
- R5: do_i is sampled in the last system cycle before each rising serial edge. The sample from period 5 is discarded, and periods 6 to 13 give data_o bits 7 down to 0.
- R6: cs_n_o returns to 1 on the falling edge that ends the last period. A short read has 14 periods and a verified read has 21.
- R7: In verified mode, periods 14 to 20 are compared with result bits 1 to 7. Any difference sets link_err_o. A short read always reports link_err_o as 0.
- R8: With the SARS check enabled at acceptance, sars_i is sampled at the same moments as periods 6 to 13, and any 0 sets proto_err_o. With the check disabled, proto_err_o is 0.
- R9: valid_o is 1 for exactly the one cycle in which cs_n_o rises. data_o and both flags change only at that point and hold until the next completion.
- R10: After cs_n_o rises, busy_o stays 1 for 2*HALF_DIV cycles. In the cycle after that, a new request can be taken.
- R11: mux_cfg_i, verify_i and sars_chk_i are captured at acceptance. Changing them during a transaction has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a conversion read |
| mux_cfg_i | input | 4 | Channel word sent after the start bit |
| verify_i | input | 1 | 1: capture and compare the second copy |
| sars_chk_i | input | 1 | 1: check the status line during the result phase |
| busy_o | output | 1 | Transaction or recovery in progress |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| di_o | output | 1 | Serial command data to the converter |
| do_i | input | 1 | Serial result data from the converter |
| sars_i | input | 1 | Converter busy-status line |
| data_o | output | 8 | Last result byte |
| valid_o | output | 1 | One-cycle pulse when a result is delivered |
| link_err_o | output | 1 | The two copies of the result disagreed |
| proto_err_o | output | 1 | The status line was low during the result phase |

## Verification
The bench's converter model drives a 1 in the discarded filler period. A controller that samples one period early then returns a shifted byte. The model flips a single bit of the second copy in both modes. A controller that compares in a short read, or misses the compare in a verified read, gets the wrong link flag. It also drops the status line for a single result period with the check on and with it off, which exposes a missing or unconditional check. The bench changes the configuration inputs and pulses the request line in the middle of a transaction, and it holds the request high across two transactions. A controller that does not latch its inputs, or that shortens or skips the recovery gap, then departs from the model's serial waveform in some cycle.

// File: rtl/adc_rd_pkg.sv
`timescale 1ns/1ps
package adc_rd_pkg;
    localparam int SLOT_W = 5;
    localparam int RES_W  = 8;
    localparam int MUX_W  = 4;
    localparam int CMD_W  = MUX_W + 1;

    // Serial periods: 0 start, 1..4 channel word, 5 filler, then the result.
    localparam logic [SLOT_W-1:0] SLOT_FILL    = SLOT_W'(CMD_W);
    localparam logic [SLOT_W-1:0] SLOT_MSB_LO  = SLOT_FILL + 1'b1;
    localparam logic [SLOT_W-1:0] SLOT_MSB_HI  = SLOT_MSB_LO + SLOT_W'(RES_W - 1);
    localparam logic [SLOT_W-1:0] SLOT_ECHO_LO = SLOT_MSB_HI + 1'b1;
    localparam logic [SLOT_W-1:0] SLOT_ECHO_HI = SLOT_MSB_HI + SLOT_W'(RES_W - 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_RECOV
    } rd_state_e;

    typedef struct packed {
        logic [MUX_W-1:0] mux;
        logic             verify;
        logic             sars_chk;
    } rd_cmd_t;

    typedef struct packed {
        logic [RES_W-1:0] data;
        logic             link_err;
        logic             proto_err;
    } rd_res_t;

    function automatic logic [SLOT_W-1:0] last_slot(input logic verify);
        return verify ? SLOT_ECHO_HI : SLOT_MSB_HI;
    endfunction

    function automatic logic in_window(input logic [SLOT_W-1:0] slot,
                                       input logic [SLOT_W-1:0] lo,
                                       input logic [SLOT_W-1:0] hi);
        return (slot >= lo) && (slot <= hi);
    endfunction
endpackage

// File: rtl/adc_rd_clkgen.sv
`timescale 1ns/1ps
module adc_rd_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    logic tick;

    generate
        if (HALF_DIV == 1) begin : g_nodiv
            assign tick = run_i;
        end else begin : g_div
            localparam int HCW = $clog2(HALF_DIV);
            localparam logic [HCW-1:0] HLAST = HCW'(HALF_DIV - 1);
            logic [HCW-1:0] hcnt;

            always_ff @(posedge clk) begin
                if (rst || !run_i) begin
                    hcnt <= '0;
                end else if (hcnt == HLAST) begin
                    hcnt <= '0;
                end else begin
                    hcnt <= hcnt + 1'b1;
                end
            end

            assign tick = run_i && (hcnt == HLAST);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_o <= 1'b0;
        end else if (tick) begin
            sclk_o <= ~sclk_o;
        end else if (!run_i) begin
            sclk_o <= 1'b0;
        end
    end

    assign rise_o = tick && !sclk_o;
    assign fall_o = tick && sclk_o;
endmodule

// File: rtl/adc_rd_seq.sv
`timescale 1ns/1ps
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              verify_q_i,
    input  logic              fall_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic              run_o,
    output logic              cs_n_o,
    output logic              busy_o,
    output logic              start_o,
    output logic              done_o
);
    localparam int REC_CYC = 2 * HALF_DIV;
    localparam int RCW     = $clog2(REC_CYC + 1);
    localparam logic [RCW-1:0] RLAST = RCW'(REC_CYC - 1);

    rd_state_e      state;
    logic [RCW-1:0] rcnt;

    assign start_o = (state == ST_IDLE) && req_i;
    assign done_o  = (state == ST_RUN) && fall_i && (slot_o == last_slot(verify_q_i));
    assign run_o   = (state == ST_RUN);
    assign busy_o  = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            slot_o <= '0;
            cs_n_o <= 1'b1;
            rcnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_i) begin
                        state  <= ST_RUN;
                        slot_o <= '0;
                        cs_n_o <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (done_o) begin
                        state  <= ST_RECOV;
                        cs_n_o <= 1'b1;
                        rcnt   <= '0;
                    end else if (fall_i) begin
                        slot_o <= slot_o + 1'b1;
                    end
                end
                ST_RECOV: begin
                    if (rcnt == RLAST) begin
                        state <= ST_IDLE;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_rd_datapath.sv
`timescale 1ns/1ps
module adc_rd_datapath
    import adc_rd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  rd_cmd_t           cmd_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic              done_i,
    input  logic              do_i,
    input  logic              sars_i,
    output logic              verify_q_o,
    output logic              di_o,
    output rd_res_t           res_o,
    output logic              valid_o
);
    logic [CMD_W-1:0] cmd_sh;
    logic [RES_W-1:0] res_sh;
    logic             chk_q;
    logic             link_acc;
    logic             proto_acc;
    logic             in_msb;
    logic             in_echo;
    logic [2:0]       eidx;

    assign in_msb  = in_window(slot_i, SLOT_MSB_LO, SLOT_MSB_HI);
    assign in_echo = in_window(slot_i, SLOT_ECHO_LO, SLOT_ECHO_HI);
    assign eidx    = 3'(slot_i - SLOT_MSB_HI);
    assign di_o    = cmd_sh[CMD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_sh     <= '0;
            res_sh     <= '0;
            chk_q      <= 1'b0;
            verify_q_o <= 1'b0;
            link_acc   <= 1'b0;
            proto_acc  <= 1'b0;
            res_o      <= '0;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= done_i;
            if (start_i) begin
                cmd_sh     <= {1'b1, cmd_i.mux};
                verify_q_o <= cmd_i.verify;
                chk_q      <= cmd_i.sars_chk;
                res_sh     <= '0;
                link_acc   <= 1'b0;
                proto_acc  <= 1'b0;
            end else begin
                if (fall_i) begin
                    cmd_sh <= cmd_sh << 1;
                end
                if (rise_i && in_msb) begin
                    res_sh <= {res_sh[RES_W-2:0], do_i};
                    if (chk_q && !sars_i) begin
                        proto_acc <= 1'b1;
                    end
                end
                if (rise_i && in_echo && (do_i != res_sh[eidx])) begin
                    link_acc <= 1'b1;
                end
                if (done_i) begin
                    res_o <= '{data: res_sh,
                               link_err: link_acc && verify_q_o,
                               proto_err: proto_acc};
                end
            end
        end
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
`timescale 1ns/1ps
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_i,
    input  logic [3:0] mux_cfg_i,
    input  logic       verify_i,
    input  logic       sars_chk_i,
    output logic       busy_o,
    output logic       cs_n_o,
    output logic       sclk_o,
    output logic       di_o,
    input  logic       do_i,
    input  logic       sars_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       link_err_o,
    output logic       proto_err_o
);
    rd_cmd_t           cmd;
    rd_res_t           res;
    logic [SLOT_W-1:0] slot;
    logic              run;
    logic              rise;
    logic              fall;
    logic              start;
    logic              done;
    logic              verify_q;

    assign cmd = '{mux: mux_cfg_i, verify: verify_i, sars_chk: sars_chk_i};

    adc_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run_i  (run),
        .sclk_o (sclk_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    adc_rd_seq #(.HALF_DIV(HALF_DIV)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_i      (req_i),
        .verify_q_i (verify_q),
        .fall_i     (fall),
        .slot_o     (slot),
        .run_o      (run),
        .cs_n_o     (cs_n_o),
        .busy_o     (busy_o),
        .start_o    (start),
        .done_o     (done)
    );

    adc_rd_datapath u_dp (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .cmd_i      (cmd),
        .rise_i     (rise),
        .fall_i     (fall),
        .slot_i     (slot),
        .done_i     (done),
        .do_i       (do_i),
        .sars_i     (sars_i),
        .verify_q_o (verify_q),
        .di_o       (di_o),
        .res_o      (res),
        .valid_o    (valid_o)
    );

    assign data_o      = res.data;
    assign link_err_o  = res.link_err;
    assign proto_err_o = res.proto_err;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
`timescale 1ns/1ps
module adc_rd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_i,
    input logic cs_n_o,
    input logic sclk_o,
    input logic di_o,
    input logic busy_o,
    input logic valid_o
);
    assert_sclk_low_released_R3: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    assert_accept_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> ($past(!busy_o) && $past(req_i)));

    assert_busy_covers_select_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |-> busy_o);

    assert_di_steady_high_R4: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(di_o));

    assert_valid_single_R9: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    assert_valid_on_release_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n_o) |-> valid_o);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .req_i   (req_i),
    .cs_n_o  (cs_n_o),
    .sclk_o  (sclk_o),
    .di_o    (di_o),
    .busy_o  (busy_o),
    .valid_o (valid_o)
);

// File: tb/adc_rd_ctrl_tb.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb;
    localparam int H = 3;
    localparam int P = 2 * H;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [3:0] mux = 4'h0;
    logic       verify = 1'b0;
    logic       chk = 1'b0;
    logic       do_r = 1'b0;
    logic       sars_r = 1'b0;
    logic       busy_o, cs_n_o, sclk_o, di_o, valid_o, link_err_o, proto_err_o;
    logic [7:0] data_o;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(.HALF_DIV(H)) u_dut (
        .clk(clk), .rst(rst), .req_i(req), .mux_cfg_i(mux), .verify_i(verify),
        .sars_chk_i(chk), .busy_o(busy_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .di_o(di_o), .do_i(do_r), .sars_i(sars_r), .data_o(data_o),
        .valid_o(valid_o), .link_err_o(link_err_o), .proto_err_o(proto_err_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // converter stimulus knobs
    logic [7:0] dev_val = 8'h00;
    bit dev_lead_one = 0, dev_corrupt = 0, dev_glitch = 0;

    // reference model state
    int m_t = -1;
    int m_n = 14;
    logic [3:0] m_mux = 4'h0;
    bit m_verify = 0, m_chk = 0, m_corr = 0, m_gl = 0;
    logic [7:0] m_val = 8'h00, m_data = 8'h00;
    bit m_link = 0, m_proto = 0;
    bit e_cs, e_sclk, e_di, e_busy, e_valid;
    int slot;

    // converter model state
    int d_state = 0, d_cnt = 0, k;
    logic [3:0] d_addr = 4'h0;
    logic d_prev = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            m_t = -1; m_data = 0; m_link = 0; m_proto = 0;
            d_state = 0; d_cnt = 0; d_addr = 0; d_prev = 0;
            do_r = 0; sars_r = 0;
        end else begin
            // expected port values in this cycle
            e_valid = 0;
            if (m_t < 0) begin
                e_cs = 1; e_sclk = 0; e_di = 0; e_busy = 0;
            end else if (m_t < m_n * P) begin
                slot = m_t / P;
                e_cs = 0; e_busy = 1;
                e_sclk = (m_t % P) >= H;
                e_di = (slot == 0) ? 1'b1 : (slot < 5) ? m_mux[4 - slot] : 1'b0;
            end else begin
                e_cs = 1; e_sclk = 0; e_di = 0; e_busy = 1;
                e_valid = (m_t == m_n * P);
                if (e_valid) begin
                    m_data = m_val;
                    m_link = m_verify && m_corr;
                    m_proto = m_chk && m_gl;
                end
            end
            check(cs_n_o == e_cs, "R6 cs_n", cs_n_o, e_cs);
            check(sclk_o == e_sclk, "R3 sclk", sclk_o, e_sclk);
            check(di_o == e_di, "R4 di", di_o, e_di);
            check(busy_o == e_busy, "R10 busy", busy_o, e_busy);
            check(valid_o == e_valid, "R9 valid", valid_o, e_valid);
            check(data_o == m_data, "R5 data", data_o, m_data);
            check(link_err_o == m_link, "R7 link_err", link_err_o, m_link);
            check(proto_err_o == m_proto, "R8 proto_err", proto_err_o, m_proto);

            // converter behaviour
            if (cs_n_o) begin
                d_state = 0; d_cnt = 0; d_addr = 0; do_r = 0; sars_r = 0;
            end else begin
                if (sclk_o && !d_prev) begin
                    if (d_state == 0) begin
                        if (di_o) begin d_state = 1; d_cnt = 0; end
                    end else if (d_state == 1) begin
                        d_addr = {d_addr[2:0], di_o};
                        d_cnt++;
                        if (d_cnt == 4) begin
                            d_state = 2;
                            check(d_addr == m_mux, "R4 address received", d_addr, m_mux);
                        end
                    end
                end
                if (!sclk_o && d_prev && d_state >= 2) begin
                    k = d_state - 2;
                    if (k == 0) begin
                        do_r = dev_lead_one; sars_r = 1;
                    end else if (k <= 8) begin
                        do_r = dev_val[8 - k]; sars_r = !(dev_glitch && k == 5);
                    end else if (k <= 15) begin
                        do_r = dev_val[k - 8] ^ (dev_corrupt && k == 12); sars_r = 0;
                    end else begin
                        do_r = 0;
                    end
                    d_state++;
                end
            end
            d_prev = sclk_o;

            // advance model to the next cycle
            if (m_t < 0) begin
                if (req) begin
                    m_t = 0; m_mux = mux; m_verify = verify; m_chk = chk;
                    m_n = verify ? 21 : 14;
                    m_val = dev_val; m_corr = dev_corrupt; m_gl = dev_glitch;
                end
            end else begin
                m_t++;
                if (m_t == (m_n + 1) * P) m_t = -1;
            end
        end
    end

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            report();
            $finish;
        end
    end

    task automatic run(input logic [3:0] m, input bit v, input bit c, input logic [7:0] val,
                       input bit lead, input bit corr, input bit gl, input bit upset);
        @(posedge clk); #1;
        while (busy_o) begin @(posedge clk); #1; end
        dev_val = val; dev_lead_one = lead; dev_corrupt = corr; dev_glitch = gl;
        mux = m; verify = v; chk = c; req = 1;
        @(posedge clk); #1;
        req = 0;
        check(busy_o == 1, "R2 accept", busy_o, 1);
        if (upset) begin
            // R11: flip every configuration input; R2: requests while busy
            mux = ~m; verify = ~v; chk = ~c;
            for (int i = 0; i < 5; i++) begin
                @(posedge clk); #1; req = 1;
                @(posedge clk); #1; req = 0;
            end
        end
        while (busy_o) begin @(posedge clk); #1; end
        check(data_o == val, upset ? "R11 data" : "R5 final data", data_o, val);
        check(link_err_o == (v && corr), upset ? "R11 link" : "R7 final link",
              link_err_o, v && corr);
        check(proto_err_o == (c && gl), "R8 final proto", proto_err_o, c && gl);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        check(cs_n_o == 1 && sclk_o == 0 && di_o == 0, "R1 serial pins", {cs_n_o, sclk_o, di_o}, 3'b100);
        check(busy_o == 0 && valid_o == 0, "R1 busy/valid", {busy_o, valid_o}, 0);
        check(data_o == 0 && link_err_o == 0 && proto_err_o == 0, "R1 result", data_o, 0);

        run(4'b1000, 0, 0, 8'h5A, 0, 0, 0, 0);  // short read
        run(4'b0110, 1, 0, 8'hA5, 0, 0, 0, 0);  // verified, clean
        run(4'b0011, 1, 0, 8'hFF, 0, 0, 0, 0);
        run(4'b1101, 1, 0, 8'h00, 0, 0, 0, 0);
        run(4'b0101, 1, 0, 8'h3C, 0, 1, 0, 0);  // R7 echo bit flipped
        run(4'b0101, 0, 0, 8'h3C, 0, 1, 0, 0);  // R7 short read ignores echo
        run(4'b1110, 0, 1, 8'h81, 0, 0, 1, 0);  // R8 status glitch caught
        run(4'b1110, 1, 1, 8'h7E, 0, 0, 0, 0);  // R8 clean status
        run(4'b1001, 1, 0, 8'h66, 0, 0, 1, 0);  // R8 check disabled
        run(4'b1111, 0, 0, 8'h01, 1, 0, 0, 0);  // R5 filler bit driven high
        run(4'b0001, 1, 0, 8'hC3, 1, 0, 0, 0);
        run(4'b1010, 1, 1, 8'h96, 0, 1, 1, 1);  // R11 inputs change mid-way
        run(4'b0100, 0, 0, 8'h2D, 0, 0, 0, 1);

        // R10: request held high across two transactions
        @(posedge clk); #1;
        dev_val = 8'hB4; dev_lead_one = 0; dev_corrupt = 0; dev_glitch = 0;
        mux = 4'b0111; verify = 1; chk = 1; req = 1;
        begin
            int seen = 0;
            while (seen < 2) begin
                @(posedge clk); #1;
                if (valid_o) seen++;
            end
        end
        req = 0;
        while (busy_o) begin @(posedge clk); #1; end
        check(data_o == 8'hB4, "R10 back-to-back data", data_o, 8'hB4);
        repeat (4) @(posedge clk);
        report();
        $finish;
    end
endmodule